// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DDR SDRAM interface. It takes the memory device from power-on to a state where ordinary traffic may start. After reset it keeps clock-enable low while supplies and clock settle. It then raises clock-enable and walks through a fixed list of commands: precharge of every bank, two extended mode register writes (delay-locked loop and on-die termination first turned off, then turned on), a NOP-only window while the loop locks, a second precharge, a further extended write, a burst of auto-refreshes, and a final mode register write. Between commands it holds the minimum spacing the device needs, and it drives NOP on every cycle in between.

Each wait is a down-counter whose length is a parameter in clock cycles. The defaults are worked out from the clock period. The register values written by the three extended writes and the mode write are parameters too, so the integrating design chooses the latency, burst, termination and loop settings. When the final mode write has settled, a done flag rises and the command port stays at NOP until the normal scheduler takes over. An asynchronous active-low reset, released through a synchronizer, or a one-cycle synchronous restart pulse sends the sequence back to its first step.

Top module: `gddr_init_seq`

## Requirements
- R1: While reset is asserted, and on the output cycle that follows a clock edge with `reinit` high, `cke` is 0, the command {cs_n,ras_n,cas_n,we_n} is NOP (0111), `ba` and `addr` are 0 and `init_done` is 0. The command is NOP on every cycle in which `cke` is low.
- R2: Counted from the clearing edge, `cke` stays low for exactly STABLE_CYC+1 output cycles. It then rises and stays high, and the first cycle with `cke` high carries NOP.
- R3: The first command is precharge-all, issued on the cycle after `cke` rises: command 0010, address bit 10 high, all other address bits 0, `ba` = 00.
- R4: Non-NOP commands come in exactly this order: precharge-all, extended write (loop off), extended write (loop on), precharge-all, extended write (run), N_REF auto-refreshes (command 0001, `ba` and `addr` 0), mode register write. Mode and extended writes use command 0000.
- R5: Extended writes drive `ba` = 01 with EMR_OFF_VAL, EMR_ON_VAL and EMR_RUN_VAL in turn. The mode write drives `ba` = 00 with MR_VAL.
- R6: The distance from each precharge to the next command is exactly TRP_CYC cycles. The distance from each refresh to the next command is exactly TRFC_CYC cycles, and only NOPs lie between them.
- R7: After the loop-on extended write, only NOPs are driven, and the second precharge follows exactly LOCK_CYC cycles later.
- R8: After the loop-off write and after the run write, the next command follows exactly TMRD_CYC cycles later. No command directly follows any mode or extended write.
- R9: `init_done` rises exactly TMRD_CYC cycles after the mode write. It then stays high while `cke` stays high and the command stays NOP.
- R10: A `reinit` pulse at any point, including while `cke` is still low or after `init_done` is high, returns the block to the R1 state, and a complete sequence satisfying R2 to R9 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reinit | input | 1 | Synchronous restart of the whole sequence |
| cke | output | 1 | Clock-enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address; selects the extended register when 01 |
| addr | output | ADDR_W | Row address bus / mode register value |
| init_done | output | 1 | High once normal traffic may begin |

## Verification
The bench builds the block with a 20-cycle stabilization wait, a 30-cycle lock window, TRP_CYC 3, TRFC_CYC 7, TMRD_CYC 4 and exactly 10 refreshes, which is the allowed minimum. With these values a whole bring-up takes under two hundred cycles, so many restarts at random points fit into one run. Because every gap has a different length, a swapped or shortened wait changes a measured distance. The four register values differ from one another and from zero, so a misplaced or wrongly banked write also shows up in the logged command trace.

// File: rtl/gis_pkg.sv
package gis_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } gis_cmd_e;

  typedef enum logic [4:0] {
    ST_PWR,
    ST_CKEUP,
    ST_PRE1,
    ST_W_PRE1,
    ST_EMR_OFF,
    ST_W_EMR_OFF,
    ST_EMR_ON,
    ST_W_LOCK,
    ST_PRE2,
    ST_W_PRE2,
    ST_EMR_RUN,
    ST_W_EMR_RUN,
    ST_REF,
    ST_W_REF,
    ST_MRS,
    ST_W_MRS,
    ST_DONE
  } gis_state_e;

  localparam logic [1:0] BA_MODE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b01;
  localparam int unsigned PRE_ALL_BIT = 10;

endpackage

// File: rtl/gis_rst_sync.sv
module gis_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[s] <= 1'b0;
          else          sync_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_i) begin
          if (!rst_n_i) sync_q[s] <= 1'b0;
          else          sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/gis_gap_timer.sv
module gis_gap_timer #(
  parameter int unsigned     CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | ld | (cnt_q != '0);

  always_comb begin
    if (clr)     cnt_d = RST_VAL;
    else if (ld) cnt_d = ld_val;
    else         cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/gis_cmd_drive.sv
module gis_cmd_drive
  import gis_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cke_d,
  input  gis_cmd_e          cmd_d,
  input  logic [1:0]        ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              done_d,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  gis_cmd_e          cmd_q;
  logic              cke_q;
  logic              done_q;
  logic [1:0]        ba_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign cke  = cke_q;
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign ba   = ba_q;
  assign addr = addr_q;
  assign done = done_q;

endmodule

// File: rtl/gddr_init_seq.sv
module gddr_init_seq
  import gis_pkg::*;
#(
  parameter int unsigned CLK_PS      = 8000,
  parameter int unsigned STABLE_CYC  = (200_000_000 + CLK_PS - 1) / CLK_PS,
  parameter int unsigned LOCK_CYC    = (1_000_000_000 + CLK_PS - 1) / CLK_PS,
  parameter int unsigned TRP_CYC     = (20_000 + CLK_PS - 1) / CLK_PS,
  parameter int unsigned TRFC_CYC    = (75_000 + CLK_PS - 1) / CLK_PS,
  parameter int unsigned TMRD_CYC    = 4,
  parameter int unsigned N_REF       = 10,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] EMR_OFF_VAL = ADDR_W'(12'h001),
  parameter logic [ADDR_W-1:0] EMR_ON_VAL  = ADDR_W'(12'h004),
  parameter logic [ADDR_W-1:0] EMR_RUN_VAL = ADDR_W'(12'h004),
  parameter logic [ADDR_W-1:0] MR_VAL      = ADDR_W'(12'h0A2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reinit,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int unsigned MAX_A   = (STABLE_CYC > LOCK_CYC) ? STABLE_CYC : LOCK_CYC;
  localparam int unsigned MAX_B   = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int unsigned MAX_C   = (MAX_B > TMRD_CYC) ? MAX_B : TMRD_CYC;
  localparam int unsigned MAX_GAP = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);
  localparam int unsigned REF_W   = $clog2(N_REF + 1);

  localparam logic [CNT_W-1:0] LD_STABLE = CNT_W'(STABLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TRP    = CNT_W'(TRP_CYC - 2);
  localparam logic [CNT_W-1:0] LD_TRFC   = CNT_W'(TRFC_CYC - 2);
  localparam logic [CNT_W-1:0] LD_TMRD   = CNT_W'(TMRD_CYC - 2);
  localparam logic [CNT_W-1:0] LD_LOCK   = CNT_W'(LOCK_CYC - 2);
  localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

  logic              rst_q_n;
  gis_state_e        state_q, state_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              tmr_ld;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_exp;
  gis_cmd_e          cmd_d;
  logic [1:0]        ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cke_d;
  logic              done_d;

  gis_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_q_n)
  );

  gis_gap_timer #(.CNT_W(CNT_W), .RST_VAL(LD_STABLE)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .clr     (reinit),
    .ld      (tmr_ld),
    .ld_val  (tmr_val),
    .expired (tmr_exp)
  );

  // Next-state and command selection
  always_comb begin
    state_d = state_q;
    ref_d   = ref_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    cmd_d   = CMD_NOP;
    ba_d    = BA_MODE;
    addr_d  = '0;
    unique case (state_q)
      ST_PWR:       if (tmr_exp) state_d = ST_CKEUP;
      ST_CKEUP:     state_d = ST_PRE1;
      ST_PRE1, ST_PRE2: begin
        cmd_d   = CMD_PRE;
        addr_d  = PRE_ALL_ADDR;
        tmr_ld  = 1'b1;
        tmr_val = LD_TRP;
        state_d = (state_q == ST_PRE1) ? ST_W_PRE1 : ST_W_PRE2;
      end
      ST_W_PRE1:    if (tmr_exp) state_d = ST_EMR_OFF;
      ST_EMR_OFF: begin
        cmd_d   = CMD_MRS;
        ba_d    = BA_EXT;
        addr_d  = EMR_OFF_VAL;
        tmr_ld  = 1'b1;
        tmr_val = LD_TMRD;
        state_d = ST_W_EMR_OFF;
      end
      ST_W_EMR_OFF: if (tmr_exp) state_d = ST_EMR_ON;
      ST_EMR_ON: begin
        cmd_d   = CMD_MRS;
        ba_d    = BA_EXT;
        addr_d  = EMR_ON_VAL;
        tmr_ld  = 1'b1;
        tmr_val = LD_LOCK;
        state_d = ST_W_LOCK;
      end
      ST_W_LOCK:    if (tmr_exp) state_d = ST_PRE2;
      ST_W_PRE2:    if (tmr_exp) state_d = ST_EMR_RUN;
      ST_EMR_RUN: begin
        cmd_d   = CMD_MRS;
        ba_d    = BA_EXT;
        addr_d  = EMR_RUN_VAL;
        tmr_ld  = 1'b1;
        tmr_val = LD_TMRD;
        state_d = ST_W_EMR_RUN;
      end
      ST_W_EMR_RUN: if (tmr_exp) state_d = ST_REF;
      ST_REF: begin
        cmd_d   = CMD_REF;
        tmr_ld  = 1'b1;
        tmr_val = LD_TRFC;
        ref_d   = ref_q + REF_W'(1);
        state_d = ST_W_REF;
      end
      ST_W_REF: if (tmr_exp) state_d = (ref_q == REF_W'(N_REF)) ? ST_MRS : ST_REF;
      ST_MRS: begin
        cmd_d   = CMD_MRS;
        ba_d    = BA_MODE;
        addr_d  = MR_VAL;
        tmr_ld  = 1'b1;
        tmr_val = LD_TMRD;
        state_d = ST_W_MRS;
      end
      ST_W_MRS:     if (tmr_exp) state_d = ST_DONE;
      ST_DONE:      state_d = ST_DONE;
      default:      state_d = ST_PWR;
    endcase
  end

  assign cke_d  = (state_q != ST_PWR);
  assign done_d = (state_q == ST_DONE);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_PWR;
      ref_q   <= '0;
    end else if (reinit) begin
      state_q <= ST_PWR;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
    end
  end

  gis_cmd_drive #(.ADDR_W(ADDR_W)) u_drive (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr    (reinit),
    .cke_d  (cke_d),
    .cmd_d  (cmd_d),
    .ba_d   (ba_d),
    .addr_d (addr_d),
    .done_d (done_d),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .addr   (addr),
    .done   (init_done)
  );

endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TRFC_CYC = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reinit,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  localparam int unsigned GW = $clog2(TRFC_CYC + 1);
  localparam logic [ADDR_W-1:0] PALL = ADDR_W'(1) << 10;

  logic [3:0]    cmd;
  logic [GW-1:0] ref_gap_q;

  assign cmd = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ref_gap_q <= '0;
    else if (reinit)            ref_gap_q <= '0;
    else if (cmd == 4'b0001)    ref_gap_q <= GW'(TRFC_CYC - 1);
    else if (ref_gap_q != '0)   ref_gap_q <= ref_gap_q - GW'(1);
  end

  AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    !cke |-> (cmd == 4'b0111) && !init_done); // R1

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    cke |=> cke); // R2

  AST_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    (cmd == 4'b0010) |-> (addr == PALL) && (ba == 2'b00)); // R3

  AST_MODE_BANK: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    (cmd == 4'b0000) |-> (ba == 2'b00) || (ba == 2'b01)); // R5

  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    (ref_gap_q != '0) |-> (cmd == 4'b0111)); // R6

  AST_MODE_GAP: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    (cmd == 4'b0000) |=> (cmd == 4'b0111)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    init_done |=> init_done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n || reinit)
    init_done |-> cke && (cmd == 4'b0111)); // R9

endmodule

bind gddr_init_seq gis_checker #(.ADDR_W(ADDR_W), .TRFC_CYC(TRFC_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reinit    (reinit),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/gddr_init_seq_tb.sv
`timescale 1ns/1ps
module gddr_init_seq_tb;

  localparam int unsigned T_STABLE = 20;
  localparam int unsigned T_LOCK   = 30;
  localparam int unsigned T_RP     = 3;
  localparam int unsigned T_RFC    = 7;
  localparam int unsigned T_MRD    = 4;
  localparam int unsigned NREF     = 10;
  localparam int unsigned AW       = 12;
  localparam logic [11:0] V_OFF = 12'h0C1;
  localparam logic [11:0] V_ON  = 12'h244;
  localparam logic [11:0] V_RUN = 12'h246;
  localparam logic [11:0] V_MR  = 12'h352;
  localparam int NEV = NREF + 6;

  logic clk = 1'b0;
  logic rst_n;
  logic reinit;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  gddr_init_seq #(
    .STABLE_CYC(T_STABLE), .LOCK_CYC(T_LOCK), .TRP_CYC(T_RP), .TRFC_CYC(T_RFC),
    .TMRD_CYC(T_MRD), .N_REF(NREF), .ADDR_W(AW),
    .EMR_OFF_VAL(V_OFF), .EMR_ON_VAL(V_ON), .EMR_RUN_VAL(V_RUN), .MR_VAL(V_MR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .reinit(reinit), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .init_done(init_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc, ev_n, cke_low, cke_rise, done_rise, quiet_bad, seed_val;
  logic [17:0] ev_sig [0:63];
  int          ev_cyc [0:63];

  task automatic chk(string req, string what, bit ok, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic arm();
    cyc = -1; ev_n = 0; cke_low = 0; cke_rise = -1; done_rise = -1; quiet_bad = 0;
  endtask

  task automatic tick();
    logic [3:0] c;
    @(negedge clk);
    cyc++;
    c = {cs_n, ras_n, cas_n, we_n};
    if (!cke && cke_rise < 0) cke_low++;
    if (cke && cke_rise < 0) cke_rise = cyc;
    if (!cke && cke_rise >= 0) quiet_bad++;
    if ((!cke || init_done) && c != 4'b0111) quiet_bad++;
    if (init_done && done_rise < 0) done_rise = cyc;
    if (c != 4'b0111 && ev_n < 64) begin
      ev_sig[ev_n] = {c, ba, addr};
      ev_cyc[ev_n] = cyc;
      ev_n++;
    end
  endtask

  function automatic logic [17:0] exp_sig(int i);
    if (i == 0 || i == 3) return {4'b0010, 2'b00, 12'h400};
    if (i == 1) return {4'b0000, 2'b01, V_OFF};
    if (i == 2) return {4'b0000, 2'b01, V_ON};
    if (i == 4) return {4'b0000, 2'b01, V_RUN};
    if (i == NEV - 1) return {4'b0000, 2'b00, V_MR};
    return {4'b0001, 2'b00, 12'h000};
  endfunction

  function automatic int exp_gap(int i);
    if (i == 1 || i == 4) return T_RP;
    if (i == 2 || i == 5) return T_MRD;
    if (i == 3) return T_LOCK;
    return T_RFC;
  endfunction

  function automatic string gap_req(int i);
    if (i == 3) return "R7";
    if (i == 2 || i == 5) return "R8";
    return "R6";
  endfunction

  function automatic string sig_req(int i);
    if (i == 1 || i == 2 || i == 4 || i == NEV - 1) return "R5";
    return "R4";
  endfunction

  task automatic check_idle(string req);
    chk(req, "idle outputs", {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done} ==
        {1'b0, 4'b0111, 2'b00, 12'h000, 1'b0},
        {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done},
        {1'b0, 4'b0111, 2'b00, 12'h000, 1'b0});
  endtask

  task automatic pulse_reinit();
    arm();
    reinit = 1'b1;
    tick();
    reinit = 1'b0;
    check_idle("R10");
  endtask

  task automatic check_run(bit exact);
    int guard = 0;
    while (done_rise < 0 && guard < 3000) begin
      tick();
      guard++;
    end
    if (exact) chk("R2", "cke low cycles", cke_low == T_STABLE + 1, cke_low, T_STABLE + 1);
    else       chk("R2", "cke low cycles min", cke_low >= T_STABLE + 1, cke_low, T_STABLE + 1);
    chk("R4", "command count", ev_n == NEV, ev_n, NEV);
    if (ev_n == NEV) begin
      chk("R3", "first precharge slot", ev_cyc[0] - cke_rise == 1, ev_cyc[0] - cke_rise, 1);
      for (int i = 0; i < NEV; i++) begin
        chk(sig_req(i), $sformatf("command %0d", i), ev_sig[i] == exp_sig(i), ev_sig[i], exp_sig(i));
        if (i > 0)
          chk(gap_req(i), $sformatf("gap before %0d", i),
              ev_cyc[i] - ev_cyc[i-1] == exp_gap(i), ev_cyc[i] - ev_cyc[i-1], exp_gap(i));
      end
      chk("R9", "done delay", done_rise - ev_cyc[NEV-1] == T_MRD,
          done_rise - ev_cyc[NEV-1], T_MRD);
    end
    begin
      int hold = $urandom_range(1, 20);
      int n0 = ev_n;
      repeat (hold) tick();
      chk("R9", "quiet after done", ev_n == n0 && init_done, ev_n, n0);
    end
    chk("R1", "nop while cke low / after done", quiet_bad == 0, quiet_bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    seed_val = $urandom(32'd20417);
    rst_n  = 1'b0;
    reinit = 1'b0;
    arm();
    repeat (4) tick();
    check_idle("R1");
    rst_n = 1'b1;
    check_run(1'b0);

    // directed: restart after done
    pulse_reinit();
    check_run(1'b1);

    // directed: restart while cke still low
    pulse_reinit();
    repeat (3) tick();
    pulse_reinit();
    check_run(1'b1);

    // random restart points mid-sequence
    for (int it = 0; it < 6; it++) begin
      pulse_reinit();
      repeat ($urandom_range(2, 170)) tick();
      pulse_reinit();
      check_run(1'b1);
    end

    // directed: asynchronous reset mid-sequence
    pulse_reinit();
    repeat ($urandom_range(25, 120)) tick();
    arm();
    rst_n = 1'b0;
    repeat (2) tick();
    check_idle("R1");
    rst_n = 1'b1;
    check_run(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule